// File: doc/BRIEF.md
# Microcontroller Low-Power Mode Controller

This block manages the two low-power states of a small 8-bit microcontroller core. The core writes a 4-bit power-control register. One bit asks for Idle and one asks for Power-down. Two more bits are general-purpose flags that software can read back. In Idle the CPU clock is gated and the oscillator keeps running. In Power-down the oscillator enable is also withdrawn. While either state is active, the block forces the address-latch and program-strobe pin levels, decides whether port 0 floats, and chooses what port 2 shows.

Idle ends when any enabled interrupt arrives. Power-down ends when either external interrupt line is asserted. This wake path raises the oscillator enable at once, without a clock edge, and clears the Power-down bit on the next edge. Both states also end on a system reset. That reset comes either from a watchdog strobe or from the external reset pin. The pin counts only after it has been sampled high on 24 consecutive oscillator edges. The flag bits keep their value across a wake-up, so an interrupt handler can tell whether it woke the device.

Top module: `pmc_core`

## Requirements
- R1: In normal mode, a register write with bit 0 = 1 and bit 1 = 0 sets the Idle bit (readback bit 0) at the next edge. While Idle is set, cpu_clk_en is 0 and osc_en is 1.
- R2: In normal mode, a register write with bit 1 = 1 sets the Power-down bit (readback bit 1) at the next edge. While it is set, cpu_clk_en is 0, and osc_en is 0 unless ext_int0, ext_int1 or rst_pin is high.
- R3: When a write has bits 1 and 0 both at 1, only the Power-down bit is set.
- R4: Every write accepted in normal mode loads flag bits 3:2 from write data bits 3:2. The flags keep their value through a low-power state and its wake-up. A system reset clears them.
- R5: While Idle is set, irq_any = 1 clears the Idle bit at the next edge. The flag bits are unchanged.
- R6: While Power-down is set, ext_int0 or ext_int1 raises osc_en in the same cycle, with no clock edge, and clears the Power-down bit at the next edge. irq_any alone has no effect in Power-down.
- R7: sys_rst asserts after rst_pin has been sampled high on 24 consecutive edges. It stays asserted while the pin stays high. A low sample restarts the count, so a pulse of 23 edges has no effect.
- R8: A wdt_rst strobe asserts sys_rst for one cycle starting at the next edge. It clears the whole register, which ends Idle or Power-down.
- R9: ale_o and psen_o are 1 in Idle and 0 in Power-down. In normal mode they follow cpu_ale and cpu_psen.
- R10: p0_float is 1 only in a low-power state with ext_mem = 1. p2_out shows p2_addr in Idle with ext_mem = 1, and shows p2_reg in Power-down or when ext_mem = 0. In normal mode p2_out shows p2_addr if ext_mem = 1 and p2_reg otherwise.
- R11: Register writes made while Idle or Power-down is set change no bit of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| reg_wr | input | 1 | Power-control register write strobe |
| reg_wdata | input | 4 | Write data: bit0 Idle, bit1 Power-down, bits 3:2 flags |
| irq_any | input | 1 | Any enabled interrupt pending |
| ext_int0 | input | 1 | External interrupt line 0 |
| ext_int1 | input | 1 | External interrupt line 1 |
| wdt_rst | input | 1 | Watchdog reset strobe |
| rst_pin | input | 1 | Raw external reset pin, active high |
| ext_mem | input | 1 | Code is fetched from external memory |
| cpu_ale | input | 1 | Address-latch level from the core in normal mode |
| cpu_psen | input | 1 | Program-strobe level from the core in normal mode |
| p2_reg | input | 8 | Port-2 register value |
| p2_addr | input | 8 | Port-2 high address byte |
| ctrl_rd | output | 4 | Register readback |
| sys_rst | output | 1 | Qualified system reset |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| ale_o | output | 1 | Address-latch pin level |
| psen_o | output | 1 | Program-strobe pin level |
| p0_float | output | 1 | Port 0 released to high impedance |
| p2_out | output | 8 | Port-2 drive value |

## Verification
Two cases are hardest to reach from the ports. The first is a reset pulse that ends exactly one edge short of qualification. The second is a reset that qualifies while the block is in Power-down. Random stimulus rarely holds rst_pin high for 23 or 24 edges in a row, so the bench drives both lengths directly. The random phase then generates reset bursts of 10 to 30 edges, mixed with writes and wake events. The combinational rise of osc_en before any edge in Power-down is checked directly, between edges.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int CTRL_W  = 4;
    localparam int IDL_BIT = 0;
    localparam int PD_BIT  = 1;

    typedef struct packed {
        logic [1:0] gf;
        logic       pd;
        logic       idl;
    } pcon_t;
endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
    parameter int LEN = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic wdt,
    output logic hit_next,
    output logic sys_rst
);
    localparam int W = $clog2(LEN + 1);
    localparam logic [W-1:0] LIM = W'(LEN);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         wdt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pin) begin
            if (st_q.cnt != LIM) st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
        st_d.wdt = wdt;
        hit_next = (st_d.cnt == LIM) | wdt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sys_rst = (st_q.cnt == LIM) | st_q.wdt;
endmodule

// File: rtl/pmc_pin_mux.sv
module pmc_pin_mux #(
    parameter int P2_W = 8
) (
    input  logic            idl,
    input  logic            pd,
    input  logic            ext_mem,
    input  logic            cpu_ale,
    input  logic            cpu_psen,
    input  logic [P2_W-1:0] p2_reg,
    input  logic [P2_W-1:0] p2_addr,
    output logic            ale_o,
    output logic            psen_o,
    output logic            p0_float,
    output logic [P2_W-1:0] p2_out
);
    logic low_pwr;
    logic show_addr;

    always_comb begin
        low_pwr   = idl | pd;
        show_addr = ext_mem & ~pd;
        if (low_pwr) begin
            ale_o  = idl;
            psen_o = idl;
        end else begin
            ale_o  = cpu_ale;
            psen_o = cpu_psen;
        end
        p0_float = low_pwr & ext_mem;
        p2_out   = show_addr ? p2_addr : p2_reg;
    end
endmodule

// File: rtl/pmc_core.sv
module pmc_core #(
    parameter int RST_LEN = 24,
    parameter int P2_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [pmc_pkg::CTRL_W-1:0] reg_wdata,
    input  logic                       irq_any,
    input  logic                       ext_int0,
    input  logic                       ext_int1,
    input  logic                       wdt_rst,
    input  logic                       rst_pin,
    input  logic                       ext_mem,
    input  logic                       cpu_ale,
    input  logic                       cpu_psen,
    input  logic [P2_W-1:0]            p2_reg,
    input  logic [P2_W-1:0]            p2_addr,
    output logic [pmc_pkg::CTRL_W-1:0] ctrl_rd,
    output logic                       sys_rst,
    output logic                       cpu_clk_en,
    output logic                       osc_en,
    output logic                       ale_o,
    output logic                       psen_o,
    output logic                       p0_float,
    output logic [P2_W-1:0]            p2_out
);
    import pmc_pkg::*;

    pcon_t ctl_d, ctl_q;
    logic  rst_hit;
    logic  ext_wake;

    pmc_rst_qual #(.LEN(RST_LEN)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (rst_pin),
        .wdt      (wdt_rst),
        .hit_next (rst_hit),
        .sys_rst  (sys_rst)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ext_wake = ext_int0 | ext_int1;
        if (rst_hit) begin
            ctl_d = '0;
        end else begin
            if (reg_wr && !ctl_q.idl && !ctl_q.pd) begin
                ctl_d.gf = reg_wdata[3:2];
                if (reg_wdata[PD_BIT])       ctl_d.pd  = 1'b1;
                else if (reg_wdata[IDL_BIT]) ctl_d.idl = 1'b1;
            end
            if (ctl_q.idl && irq_any) ctl_d.idl = 1'b0;
            if (ctl_q.pd && ext_wake) ctl_d.pd  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctrl_rd    = ctl_q;
    assign cpu_clk_en = ~(ctl_q.idl | ctl_q.pd);
    assign osc_en     = ~ctl_q.pd | ext_int0 | ext_int1 | rst_pin;

    pmc_pin_mux #(.P2_W(P2_W)) u_pins (
        .idl      (ctl_q.idl),
        .pd       (ctl_q.pd),
        .ext_mem  (ext_mem),
        .cpu_ale  (cpu_ale),
        .cpu_psen (cpu_psen),
        .p2_reg   (p2_reg),
        .p2_addr  (p2_addr),
        .ale_o    (ale_o),
        .psen_o   (psen_o),
        .p0_float (p0_float),
        .p2_out   (p2_out)
    );
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [3:0] reg_wdata,
    input logic       irq_any,
    input logic       ext_int0,
    input logic       ext_int1,
    input logic       wdt_rst,
    input logic       rst_pin,
    input logic [3:0] ctrl_rd,
    input logic       sys_rst,
    input logic       cpu_clk_en,
    input logic       osc_en,
    input logic       ale_o,
    input logic       psen_o
);
    assert_idle_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && cpu_clk_en && reg_wdata[1:0] == 2'b01 && !wdt_rst && !rst_pin)
        |=> (ctrl_rd[0] && !cpu_clk_en && osc_en));

    assert_pd_stops_osc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[1] && !ext_int0 && !ext_int1 && !rst_pin) |-> (!osc_en && !cpu_clk_en));

    assert_pd_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && cpu_clk_en && reg_wdata[1:0] == 2'b11 && !wdt_rst && !rst_pin)
        |=> (ctrl_rd[1] && !ctrl_rd[0]));

    assert_idle_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[0] && irq_any) |=> !ctrl_rd[0]);

    assert_pd_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[1] && (ext_int0 || ext_int1)) |=> !ctrl_rd[1]);

    assert_pd_osc_async_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[1] && (ext_int0 || ext_int1)) |-> osc_en);

    assert_wdt_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> (sys_rst && ctrl_rd == 4'b0000));

    assert_reset_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> (ctrl_rd == 4'b0000));

    assert_idle_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[0] |-> (ale_o && psen_o));

    assert_pd_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[1] |-> (!ale_o && !psen_o));

    assert_no_lp_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && reg_wr && !irq_any && !ext_int0 && !ext_int1 && !wdt_rst && !rst_pin)
        |=> $stable(ctrl_rd));
endmodule

bind pmc_core pmc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .irq_any    (irq_any),
    .ext_int0   (ext_int0),
    .ext_int1   (ext_int1),
    .wdt_rst    (wdt_rst),
    .rst_pin    (rst_pin),
    .ctrl_rd    (ctrl_rd),
    .sys_rst    (sys_rst),
    .cpu_clk_en (cpu_clk_en),
    .osc_en     (osc_en),
    .ale_o      (ale_o),
    .psen_o     (psen_o)
);

// File: tb/sim_pmc_core.sv
module sim_pmc_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_wdata = '0;
    logic       irq_any = 1'b0, ext_int0 = 1'b0, ext_int1 = 1'b0;
    logic       wdt_rst = 1'b0, rst_pin = 1'b0, ext_mem = 1'b0;
    logic       cpu_ale = 1'b0, cpu_psen = 1'b0;
    logic [7:0] p2_reg = 8'h5A, p2_addr = 8'hC3;
    logic [3:0] ctrl_rd;
    logic       sys_rst, cpu_clk_en, osc_en, ale_o, psen_o, p0_float;
    logic [7:0] p2_out;

    always #4 clk = ~clk;

    pmc_core u0 (.*);

    int total = 0;
    int bad   = 0;
    int m_cnt = 0;
    logic m_wdt = 1'b0;
    logic [3:0] m_ctl = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] next_ctl(input logic [3:0] c, input logic hit);
        logic [3:0] n;
        n = c;
        if (hit) return 4'b0000;
        if (reg_wr && c[1:0] == 2'b00) begin
            n[3:2] = reg_wdata[3:2];
            if (reg_wdata[1])      n[1] = 1'b1;
            else if (reg_wdata[0]) n[0] = 1'b1;
        end
        if (c[0] && irq_any) n[0] = 1'b0;
        if (c[1] && (ext_int0 || ext_int1)) n[1] = 1'b0;
        return n;
    endfunction

    task automatic model_edge();
        logic hit;
        if (rst_pin) m_cnt = (m_cnt < 24) ? m_cnt + 1 : 24;
        else         m_cnt = 0;
        hit   = (m_cnt == 24) || wdt_rst;
        m_ctl = next_ctl(m_ctl, hit);
        m_wdt = wdt_rst;
    endtask

    task automatic check_all();
        logic lp;
        lp = m_ctl[0] | m_ctl[1];
        chk("R1 R2 R3 R4 R5 R6 R11 ctrl_rd", ctrl_rd, m_ctl);
        chk("R7 R8 sys_rst", sys_rst, (m_cnt == 24) || m_wdt);
        chk("R1 R2 cpu_clk_en", cpu_clk_en, !lp);
        chk("R2 R6 osc_en", osc_en, !m_ctl[1] || ext_int0 || ext_int1 || rst_pin);
        chk("R9 ale_o", ale_o, lp ? m_ctl[0] : cpu_ale);
        chk("R9 psen_o", psen_o, lp ? m_ctl[0] : cpu_psen);
        chk("R10 p0_float", p0_float, lp && ext_mem);
        chk("R10 p2_out", p2_out, (ext_mem && !m_ctl[1]) ? p2_addr : p2_reg);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        #1;
        check_all();
    endtask

    task automatic wr(input logic [3:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        cyc();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #20 rst_n = 1'b1;
        #3;
        check_all();                                   // reset state, R4
        cyc();

        // R1 and R4: Idle with flag 0, then wake (R5)
        ext_mem = 1'b1;
        wr(4'b0101);
        chk("R1 idle set", ctrl_rd[0], 1'b1);
        chk("R10 p2 addr in idle", p2_out, p2_addr);
        wr(4'b0010);                                   // R11 ignored in Idle
        chk("R11 write ignored", ctrl_rd, 4'b0101);
        irq_any = 1'b1; cyc(); irq_any = 1'b0;
        chk("R5 idle cleared, flag kept", ctrl_rd, 4'b0100);

        // R3: both bits, Power-down wins
        wr(4'b1011);
        chk("R3 pd priority", ctrl_rd, 4'b1010);
        chk("R10 p2 reg in pd", p2_out, p2_reg);
        irq_any = 1'b1; cyc(); irq_any = 1'b0;
        chk("R6 irq ignored in pd", ctrl_rd, 4'b1010);
        ext_int1 = 1'b1; #1;
        chk("R6 osc async", osc_en, 1'b1);
        chk("R6 pd still set", ctrl_rd[1], 1'b1);
        cyc(); ext_int1 = 1'b0;
        chk("R6 pd cleared flags kept", ctrl_rd, 4'b1000);

        // R7: 23-edge pulse has no effect, 24 qualifies
        rst_pin = 1'b1;
        for (int i = 0; i < 23; i++) cyc();
        rst_pin = 1'b0; cyc();
        chk("R7 short pulse", ctrl_rd, 4'b1000);
        wr(4'b0010);                                   // Power-down, then reset
        rst_pin = 1'b1;
        for (int i = 0; i < 23; i++) cyc();
        chk("R7 not yet", sys_rst, 1'b0);
        cyc();
        chk("R7 qualified", sys_rst, 1'b1);
        chk("R7 ends pd", ctrl_rd, 4'b0000);
        rst_pin = 1'b0; cyc();

        // R8: watchdog ends Idle
        wr(4'b1101);
        wdt_rst = 1'b1; cyc(); wdt_rst = 1'b0;
        chk("R8 wdt reset", {28'd0, sys_rst, ctrl_rd}, {28'd0, 1'b1, 4'b0000});
        cyc();
        chk("R8 one cycle", sys_rst, 1'b0);

        // random phase
        begin
            int burst = 0;
            for (int n = 0; n < 4000; n++) begin
                reg_wr    = ($urandom % 6) == 0;
                reg_wdata = 4'($urandom);
                irq_any   = ($urandom % 8) == 0;
                ext_int0  = ($urandom % 12) == 0;
                ext_int1  = ($urandom % 12) == 0;
                wdt_rst   = ($urandom % 300) == 0;
                ext_mem   = 1'($urandom);
                cpu_ale   = 1'($urandom);
                cpu_psen  = 1'($urandom);
                p2_reg    = 8'($urandom);
                p2_addr   = 8'($urandom);
                if (burst == 0 && ($urandom % 150) == 0) burst = 10 + ($urandom % 21);
                rst_pin = (burst > 0);
                if (burst > 0) burst--;
                cyc();
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule